// File: doc/BRIEF.md
# Dual 16-bit Multiply-Accumulate Unit

This unit is a pipelined signed datapath for packed half-word arithmetic. It takes two 32-bit operands, splits each into a low and a high signed 16-bit half, and forms the two half-by-half products. It then adds or subtracts the high-half product from the low-half product. When the decoded form asks for it, it also adds a 32-bit accumulator. Before multiplying, it can exchange the two halves of the second operand.

The caller supplies the three operand values and the 32-bit instruction word. The unit decodes only the bits that pick the form and the swap. Register indices are resolved upstream and are not used here. Transfers on both sides use a valid/ready handshake. Each accepted instruction produces one output beat, which carries the 32-bit result and a flag that marks an instruction word that matches no form.

Top module: `dual_mac16`

## Requirements
- R1: When `(insn & 32'hF0D0) == 32'hF010`, the result is `lo(rn)*lo(rm') + hi(rn)*hi(rm')` and `ra_val` is ignored. Here lo is bits [15:0], hi is bits [31:16], and rm' is rm after the optional swap.
- R2: When `(insn & 32'hF0D0) == 32'hF050`, the result is `lo(rn)*lo(rm') - hi(rn)*hi(rm')` and `ra_val` is ignored.
- R3: When R1 and R2 do not match and `(insn & 32'h00D0) == 32'h0010`, the result is the R1 sum plus `ra_val`. A field value of 4'hF in bits [15:12] therefore selects R1, and the accumulator is not added.
- R4: When R1 and R2 do not match and `(insn & 32'h00D0) == 32'h0050`, the result is the R2 difference plus `ra_val`.
- R5: When `insn[5]` is 1, the two halves of `rm_val` are exchanged before multiplying. When it is 0, they are used in place.
- R6: All halves are signed 16-bit values and the accumulator is a signed 32-bit value. The result wraps modulo 2^32 without saturation.
- R7: An instruction word that matches none of the four forms gives `out_illegal = 1` and `out_result = 0`. A legal word gives `out_illegal = 0`.
- R8: With `out_ready` held high, the output beat for an input accepted at rising edge k is valid after edge k+2 and is not valid after edge k+1.
- R9: While `out_valid` is high and `out_ready` is low, the output beat holds steady. Once both stages are full, `in_ready` falls. No accepted beat is lost or reordered.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Unit can take an input beat |
| insn | input | 32 | Instruction word that selects form and swap |
| rn_val | input | 32 | First packed operand |
| rm_val | input | 32 | Second packed operand, swappable |
| ra_val | input | 32 | Accumulator value |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_result | output | 32 | Combined result |
| out_illegal | output | 1 | Instruction word matched no form |

## Verification
An input beat crosses two registers: the product stage and the combine stage. With the consumer ready, its result therefore appears after the second rising edge that follows acceptance, and nothing is shown after the first. Each directed scenario drives its inputs at a falling edge and samples at the falling edge after the first rising edge to confirm that no result is shown yet. It then samples again one edge later to compare result and flag against a model computed from the requirements. The back-pressure scenario counts edges in the same way. It confirms the stall on the third edge, checks that the beat holds across idle edges, and then sees the two queued beats one edge apart once the consumer is ready.

// File: rtl/dmac_pkg.sv
// Package dmac_pkg
// Holds the shared operation encoding and the instruction-word decode constants
// for the dual multiply-accumulate unit. Assumes a 32-bit instruction word.
package dmac_pkg;

    localparam int INSN_W   = 32;
    localparam int SWAP_BIT = 5;

    localparam logic [INSN_W-1:0] PLAIN_MASK = 32'h0000_F0D0;
    localparam logic [INSN_W-1:0] PLAIN_SUM  = 32'h0000_F010;
    localparam logic [INSN_W-1:0] PLAIN_DIFF = 32'h0000_F050;
    localparam logic [INSN_W-1:0] ACC_MASK   = 32'h0000_00D0;
    localparam logic [INSN_W-1:0] ACC_SUM    = 32'h0000_0010;
    localparam logic [INSN_W-1:0] ACC_DIFF   = 32'h0000_0050;

    typedef enum logic [2:0] {
        OP_ILLEGAL  = 3'd0,
        OP_SUM      = 3'd1,
        OP_DIFF     = 3'd2,
        OP_SUM_ACC  = 3'd3,
        OP_DIFF_ACC = 3'd4
    } dmac_op_e;

    // True when the form subtracts the high-half product.
    function automatic logic op_is_diff(dmac_op_e op);
        return (op == OP_DIFF) || (op == OP_DIFF_ACC);
    endfunction

    // True when the form adds the accumulator.
    function automatic logic op_uses_acc(dmac_op_e op);
        return (op == OP_SUM_ACC) || (op == OP_DIFF_ACC);
    endfunction

endpackage

// File: rtl/dmac_decode.sv
// Module dmac_decode
// Maps an instruction word to one of the four arithmetic forms, or to illegal,
// and extracts the operand-swap bit. The non-accumulating forms are tested
// first, so an accumulator field of all ones selects the plain form.
module dmac_decode
    import dmac_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dmac_op_e          op,
    output logic              swap
);

    // Priority decode of the form select bits.
    always_comb begin
        if ((insn & PLAIN_MASK) == PLAIN_SUM)       op = OP_SUM;
        else if ((insn & PLAIN_MASK) == PLAIN_DIFF) op = OP_DIFF;
        else if ((insn & ACC_MASK) == ACC_SUM)      op = OP_SUM_ACC;
        else if ((insn & ACC_MASK) == ACC_DIFF)     op = OP_DIFF_ACC;
        else                                        op = OP_ILLEGAL;
    end

    assign swap = insn[SWAP_BIT];

endmodule

// File: rtl/dmac_mul_stage.sv
// Module dmac_mul_stage
// First pipeline stage. It optionally exchanges the halves of the second
// operand, forms the two signed half-by-half products, and registers them
// together with the accumulator and decoded form. It loads only when
// load_en is high and holds otherwise.
module dmac_mul_stage
    import dmac_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_en,
    input  logic                     in_valid,
    input  logic [WORD_W-1:0]        rn,
    input  logic [WORD_W-1:0]        rm,
    input  logic [WORD_W-1:0]        ra,
    input  dmac_op_e                 op_in,
    input  logic                     swap,
    output logic                     q_valid,
    output logic signed [WORD_W-1:0] q_prod_lo,
    output logic signed [WORD_W-1:0] q_prod_hi,
    output logic [WORD_W-1:0]        q_acc,
    output dmac_op_e                 q_op
);

    localparam int LANES = 2;

    logic [WORD_W-1:0]        rm_eff;
    logic signed [WORD_W-1:0] prod_d [LANES];

    assign rm_eff = swap ? {rm[HALF_W-1:0], rm[WORD_W-1:HALF_W]} : rm;

    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        logic signed [WORD_W-1:0] ext_a;
        logic signed [WORD_W-1:0] ext_b;
        assign ext_a = {{HALF_W{rn[lane*HALF_W+HALF_W-1]}}, rn[lane*HALF_W +: HALF_W]};
        assign ext_b = {{HALF_W{rm_eff[lane*HALF_W+HALF_W-1]}}, rm_eff[lane*HALF_W +: HALF_W]};
        assign prod_d[lane] = ext_a * ext_b;
    end

    // Stage register: capture products and control when the next stage has room.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid   <= 1'b0;
            q_prod_lo <= '0;
            q_prod_hi <= '0;
            q_acc     <= '0;
            q_op      <= OP_ILLEGAL;
        end else if (load_en) begin
            q_valid   <= in_valid;
            q_prod_lo <= prod_d[0];
            q_prod_hi <= prod_d[1];
            q_acc     <= ra;
            q_op      <= op_in;
        end
    end

endmodule

// File: rtl/dmac_sum_stage.sv
// Module dmac_sum_stage
// Second pipeline stage. It adds or subtracts the registered products, adds
// the accumulator for the accumulating forms, and registers the wrapped
// result. An illegal form yields a zero result with the illegal flag set.
module dmac_sum_stage
    import dmac_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_en,
    input  logic                     in_valid,
    input  logic signed [WORD_W-1:0] prod_lo,
    input  logic signed [WORD_W-1:0] prod_hi,
    input  logic [WORD_W-1:0]        acc,
    input  dmac_op_e                 op,
    output logic                     q_valid,
    output logic [WORD_W-1:0]        q_result,
    output logic                     q_illegal
);

    logic [WORD_W-1:0] pair;
    logic [WORD_W-1:0] addend;
    logic [WORD_W-1:0] total;
    logic              bad;

    // Combine products and accumulator, modulo 2^WORD_W.
    always_comb begin
        pair   = op_is_diff(op) ? WORD_W'(prod_lo - prod_hi) : WORD_W'(prod_lo + prod_hi);
        addend = op_uses_acc(op) ? acc : '0;
        bad    = (op == OP_ILLEGAL);
        total  = bad ? '0 : pair + addend;
    end

    // Output register: load when the consumer side has room.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid   <= 1'b0;
            q_result  <= '0;
            q_illegal <= 1'b0;
        end else if (load_en) begin
            q_valid   <= in_valid;
            q_result  <= total;
            q_illegal <= bad;
        end
    end

endmodule

// File: rtl/dual_mac16.sv
// Module dual_mac16
// Top level of the dual half-word multiply-accumulate unit. It decodes the
// instruction word, forms products in stage one, and combines them in stage
// two. Each stage advances when the stage after it is empty or draining, so
// back-pressure from the output reaches in_ready through two gates.
// Assumes the caller keeps input beats steady while in_valid is high and
// in_ready is low.
module dual_mac16
    import dmac_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [INSN_W-1:0] insn,
    input  logic [WORD_W-1:0] rn_val,
    input  logic [WORD_W-1:0] rm_val,
    input  logic [WORD_W-1:0] ra_val,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_result,
    output logic              out_illegal
);

    dmac_op_e                 dec_op;
    logic                     dec_swap;
    logic                     s1_valid;
    logic signed [WORD_W-1:0] s1_prod_lo;
    logic signed [WORD_W-1:0] s1_prod_hi;
    logic [WORD_W-1:0]        s1_acc;
    dmac_op_e                 s1_op;
    logic                     s2_free;
    logic                     s1_free;

    // Stage-advance conditions, from the output backwards.
    assign s2_free  = !out_valid || out_ready;
    assign s1_free  = !s1_valid || s2_free;
    assign in_ready = s1_free;

    dmac_decode u_decode (
        .insn (insn),
        .op   (dec_op),
        .swap (dec_swap)
    );

    dmac_mul_stage #(.HALF_W(HALF_W)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (s1_free),
        .in_valid  (in_valid),
        .rn        (rn_val),
        .rm        (rm_val),
        .ra        (ra_val),
        .op_in     (dec_op),
        .swap      (dec_swap),
        .q_valid   (s1_valid),
        .q_prod_lo (s1_prod_lo),
        .q_prod_hi (s1_prod_hi),
        .q_acc     (s1_acc),
        .q_op      (s1_op)
    );

    dmac_sum_stage #(.HALF_W(HALF_W)) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (s2_free),
        .in_valid  (s1_valid),
        .prod_lo   (s1_prod_lo),
        .prod_hi   (s1_prod_hi),
        .acc       (s1_acc),
        .op        (s1_op),
        .q_valid   (out_valid),
        .q_result  (out_result),
        .q_illegal (out_illegal)
    );

endmodule

// File: rtl/dmac_checks.sv
// Module dmac_checks
// Port-level properties of dual_mac16, attached by bind. Covers the reset
// state, the illegal-result encoding, the two-edge latency and the
// hold-under-back-pressure behaviour.
module dmac_checks #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_result,
    input logic              out_illegal
);

    // R10: after a reset edge no output beat is shown.
    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R7: an illegal beat always carries a zero result.
    assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_result == '0));

    // R8: a new output beat traces back to an acceptance two edges earlier.
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready, 2));

    // R9: a stalled output beat holds its value and flag.
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

    // R9: input is refused only while a beat waits at a stalled output.
    assert_full_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));

endmodule

bind dual_mac16 dmac_checks #(.WORD_W(WORD_W)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/dual_mac16_test.sv
`timescale 1ns/1ps
module dual_mac16_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] insn = '0;
    logic [31:0] rn_val = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] ra_val = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_result;
    logic        out_illegal;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    dual_mac16 uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .insn        (insn),
        .rn_val      (rn_val),
        .rm_val      (rm_val),
        .ra_val      (ra_val),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_result  (out_result),
        .out_illegal (out_illegal)
    );

    // Record one comparison.
    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Model built from the requirements R1..R7.
    function automatic logic [32:0] model(input logic [31:0] w, input logic [31:0] a,
                                          input logic [31:0] b, input logic [31:0] c);
        logic [31:0] bs;
        longint lo_p, hi_p, acc, r;
        logic bad;
        bs   = w[5] ? {b[15:0], b[31:16]} : b;
        lo_p = longint'($signed(a[15:0])) * longint'($signed(bs[15:0]));
        hi_p = longint'($signed(a[31:16])) * longint'($signed(bs[31:16]));
        acc  = longint'($signed(c));
        bad  = 1'b0;
        if ((w & 32'hF0D0) == 32'hF010)      r = lo_p + hi_p;
        else if ((w & 32'hF0D0) == 32'hF050) r = lo_p - hi_p;
        else if ((w & 32'h00D0) == 32'h0010) r = lo_p + hi_p + acc;
        else if ((w & 32'h00D0) == 32'h0050) r = lo_p - hi_p + acc;
        else begin r = 0; bad = 1'b1; end
        return {bad, r[31:0]};
    endfunction

    // One beat with the consumer ready: no result after one edge, result after two.
    task automatic run_one(input string req, input logic [31:0] w, input logic [31:0] a,
                           input logic [31:0] b, input logic [31:0] c);
        logic [32:0] e;
        e = model(w, a, b, c);
        @(negedge clk);
        out_ready = 1'b1;
        insn = w; rn_val = a; rm_val = b; ra_val = c; in_valid = 1'b1;
        check(req, "in_ready before accept", {31'd0, in_ready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "out_valid one edge after accept", {31'd0, out_valid}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        check("R8", "out_valid two edges after accept", {31'd0, out_valid}, 32'd1);
        check(req, "result", out_result, e[31:0]);
        check(req, "illegal flag", {31'd0, out_illegal}, {31'd0, e[32]});
    endtask

    task automatic test_reset;
        @(negedge clk);
        check("R10", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        check("R10", "in_ready after reset", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic test_forms;
        run_one("R1", 32'h0702_F013, 32'h0003_0002, 32'h0005_0004, 32'h0000_0064);
        run_one("R2", 32'h0702_F053, 32'h0003_0002, 32'h0005_0004, 32'h0000_0064);
        run_one("R3", 32'h0702_3013, 32'h0003_0002, 32'h0005_0004, 32'h0000_0064);
        run_one("R4", 32'h0702_3053, 32'h0003_0002, 32'h0005_0004, 32'h0000_0064);
        // R3 priority: field 4'hF with a nonzero accumulator must not add it.
        run_one("R3", 32'h0702_F013, 32'h0001_0001, 32'h0001_0001, 32'h1234_0000);
    endtask

    task automatic test_swap;
        run_one("R5", 32'h0702_F033, 32'h0003_0002, 32'h0005_0004, 32'h0);
        run_one("R5", 32'h0702_3073, 32'h0010_0002, 32'h0100_0007, 32'h0000_0009);
    endtask

    task automatic test_signed_wrap;
        run_one("R6", 32'h0702_F013, 32'h8000_8000, 32'h8000_8000, 32'h0);
        run_one("R6", 32'h0702_F053, 32'hFFFF_7FFF, 32'h7FFF_FFFF, 32'h0);
        run_one("R6", 32'h0702_3013, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF);
    endtask

    task automatic test_illegal;
        run_one("R7", 32'h0000_0000, 32'h0003_0002, 32'h0005_0004, 32'h0000_0064);
        run_one("R7", 32'h0702_30F3, 32'h0003_0002, 32'h0005_0004, 32'h0000_0064);
    endtask

    // Three beats against a stalled consumer, then release.
    task automatic test_backpressure;
        logic [32:0] e1, e2, e3;
        e1 = model(32'h0702_F013, 32'h0001_0002, 32'h0003_0004, 32'h0);
        e2 = model(32'h0702_F053, 32'h0005_0006, 32'h0007_0008, 32'h0);
        e3 = model(32'h0702_2013, 32'h0009_000A, 32'h000B_000C, 32'h0000_0100);
        @(negedge clk);
        out_ready = 1'b0;
        insn = 32'h0702_F013; rn_val = 32'h0001_0002; rm_val = 32'h0003_0004; ra_val = 32'h0;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        insn = 32'h0702_F053; rn_val = 32'h0005_0006; rm_val = 32'h0007_0008;
        @(posedge clk);
        @(negedge clk);
        insn = 32'h0702_2013; rn_val = 32'h0009_000A; rm_val = 32'h000B_000C; ra_val = 32'h0000_0100;
        @(posedge clk);
        @(negedge clk);
        check("R9", "in_ready when full", {31'd0, in_ready}, 32'd0);
        check("R9", "first beat at stalled output", out_result, e1[31:0]);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R9", "held result", out_result, e1[31:0]);
            check("R9", "held valid", {31'd0, out_valid}, 32'd1);
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", "second beat after release", out_result, e2[31:0]);
        @(posedge clk);
        @(negedge clk);
        check("R9", "third beat after release", out_result, e3[31:0]);
        check("R9", "third beat valid", {31'd0, out_valid}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        check("R9", "drained", {31'd0, out_valid}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_forms();
        test_swap();
        test_signed_wrap();
        test_illegal();
        test_backpressure();
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule